// File: doc/BRIEF.md
# Relative Branch Condition Unit

This block decodes the short relative branch instructions of a 16-bit coprocessor and works out where fetch goes next. Each branch is one opcode byte followed by a signed 8-bit displacement. The unit receives the opcode, the displacement, the address of the opcode byte and the four condition flags: sign, zero, carry and overflow. One cycle later it reports three things: whether the byte was a branch, whether that branch is taken, and the two candidate addresses. The fall-through address is the byte just after the displacement. The target is that same address plus the sign-extended displacement.

Every branch is followed by one delay-slot instruction. The byte after the displacement is always executed, whether or not the branch is taken. For a taken branch, the unit holds the target until the execute stage reports that the delay-slot instruction has finished. It then raises a single-cycle redirect carrying the target. A branch that is not taken never produces a redirect.

Top module: `rb_branch_unit`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, every output is 0 and no redirect is pending.
- R2: Opcodes 0x05 to 0x0F are branches, so `is_br_o` is 1 for them. Every other opcode gives `is_br_o` = 0 and `taken_o` = 0.
- R3: Opcode 0x05 is taken under every flag combination.
- R4: Opcode 0x06 is taken when (S xor OV) is 0. Opcode 0x07 is taken when (S xor OV) is 1.
- R5: Opcode 0x08 is taken when Z is 0. Opcode 0x09 is taken when Z is 1.
- R6: Opcode 0x0A is taken when S is 0. Opcode 0x0B is taken when S is 1.
- R7: Opcodes 0x0C and 0x0D are taken when CY is 0 and 1 respectively. Opcodes 0x0E and 0x0F are taken when OV is 0 and 1 respectively.
- R8: `target_o` equals (pc + 2 + sign-extended displacement) mod 2^16. The displacement is a two's-complement byte, and the sum wraps within the 16-bit bank.
- R9: `fall_pc_o` equals (pc + 2) mod 2^16, which is the delay-slot address. It is reported whether or not the branch is taken.
- R10: For a taken branch, `redirect_o` stays low until `slot_done_i` is sampled high. It is then high for exactly the next cycle, with `redirect_pc_o` equal to the target.
- R11: A branch that is not taken, or a non-branch opcode, causes no redirect, even when `slot_done_i` is then pulsed.
- R12: The decode outputs are registered. `dec_valid_o` is high for exactly the one cycle that follows a sampled `issue_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Opcode, displacement, pc and flags are valid this cycle |
| opcode_i | input | 8 | Opcode byte |
| disp_i | input | 8 | Signed displacement byte |
| pc_i | input | 16 | Address of the opcode byte |
| flag_s_i | input | 1 | Sign flag |
| flag_z_i | input | 1 | Zero flag |
| flag_cy_i | input | 1 | Carry flag |
| flag_ov_i | input | 1 | Overflow flag |
| slot_done_i | input | 1 | Delay-slot instruction has finished |
| dec_valid_o | output | 1 | Decode result valid (one cycle) |
| is_br_o | output | 1 | Opcode is a relative branch |
| taken_o | output | 1 | Branch condition holds |
| fall_pc_o | output | 16 | Delay-slot / not-taken address |
| target_o | output | 16 | Branch target address |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 16 | Address for the redirect |

## Verification
The assertions take for granted that no new instruction is issued while a taken branch is waiting for its delay slot to finish. A branch cannot sit in the delay slot of another branch.

The stimulus respects this by always completing the delay-slot handshake before it issues the next vector. It pulses `slot_done_i` once per vector, sometimes after a few idle cycles, and it never raises `issue_i` during that window. The sweep covers all 256 opcodes against all 16 flag combinations, with pc and displacement values that walk through both wrap directions.

// File: rtl/rb_pkg.sv
package rb_pkg;

  typedef struct packed {
    logic s;
    logic z;
    logic cy;
    logic ov;
  } rb_flags_t;

  typedef enum logic [3:0] {
    RB_ALWAYS = 4'd0,
    RB_GE     = 4'd1,
    RB_LT     = 4'd2,
    RB_NE     = 4'd3,
    RB_EQ     = 4'd4,
    RB_PL     = 4'd5,
    RB_MI     = 4'd6,
    RB_CC     = 4'd7,
    RB_CS     = 4'd8,
    RB_VC     = 4'd9,
    RB_VS     = 4'd10,
    RB_NONE   = 4'd15
  } rb_cond_e;

  localparam int unsigned RB_NUM_COND = 11;

endpackage

// File: rtl/rb_rst_sync.sv
module rb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/rb_cond.sv
module rb_cond
  import rb_pkg::*;
#(
  parameter int unsigned       OP_W    = 8,
  parameter logic [OP_W-1:0]   OP_BASE = 8'h05
) (
  input  logic [OP_W-1:0] opcode,
  input  rb_flags_t       flags,
  output logic            is_br,
  output logic            take
);
  localparam logic [OP_W-1:0] OP_LAST = OP_BASE + OP_W'(RB_NUM_COND - 1);

  logic [OP_W-1:0] offs;
  rb_cond_e        sel;
  logic            lt_signed;

  assign offs      = opcode - OP_BASE;
  assign is_br     = (opcode >= OP_BASE) && (opcode <= OP_LAST);
  assign lt_signed = flags.s ^ flags.ov;

  always_comb begin
    sel = RB_NONE;
    if (is_br) sel = rb_cond_e'(offs[3:0]);
  end

  always_comb begin
    unique case (sel)
      RB_ALWAYS: take = 1'b1;
      RB_GE:     take = ~lt_signed;
      RB_LT:     take = lt_signed;
      RB_NE:     take = ~flags.z;
      RB_EQ:     take = flags.z;
      RB_PL:     take = ~flags.s;
      RB_MI:     take = flags.s;
      RB_CC:     take = ~flags.cy;
      RB_CS:     take = flags.cy;
      RB_VC:     take = ~flags.ov;
      RB_VS:     take = flags.ov;
      default:   take = 1'b0;
    endcase
  end

  always_comb begin
    if (take) assert (is_br) else $error("p_take_only_branch_r2");
  end
endmodule

// File: rtl/rb_target.sv
module rb_target #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned SKIP   = 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] fall_pc,
  output logic [ADDR_W-1:0] tgt_pc
);
  logic [ADDR_W-1:0] disp_x;

  generate
    if (ADDR_W > DISP_W) begin : g_ext
      assign disp_x = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_x = disp[ADDR_W-1:0];
    end
  endgenerate

  assign fall_pc = pc + ADDR_W'(SKIP);
  assign tgt_pc  = fall_pc + disp_x;
endmodule

// File: rtl/rb_slot.sv
module rb_slot #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              issue,
  input  logic              load_taken,
  input  logic [ADDR_W-1:0] load_pc,
  input  logic              slot_done,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirect_pc
);
  logic              pend_q, pend_d;
  logic              redir_q, redir_d;
  logic [ADDR_W-1:0] hold_q, hold_d;
  logic [ADDR_W-1:0] rpc_q, rpc_d;
  logic              hold_en, rpc_en;

  always_comb begin
    pend_d  = pend_q;
    redir_d = 1'b0;
    hold_en = 1'b0;
    rpc_en  = 1'b0;
    hold_d  = load_pc;
    rpc_d   = hold_q;
    if (pend_q) begin
      if (slot_done) begin
        pend_d  = 1'b0;
        redir_d = 1'b1;
        rpc_en  = 1'b1;
      end
    end else if (load_taken) begin
      pend_d  = 1'b1;
      hold_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pend_q  <= 1'b0;
      redir_q <= 1'b0;
      hold_q  <= '0;
      rpc_q   <= '0;
    end else begin
      pend_q  <= pend_d;
      redir_q <= redir_d;
      if (hold_en) hold_q <= hold_d;
      if (rpc_en)  rpc_q  <= rpc_d;
    end
  end

  assign redirect    = redir_q;
  assign redirect_pc = rpc_q;

  // no new instruction may issue while the delay slot is outstanding
  p_no_issue_in_slot_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    pend_q |-> !issue);
  p_redirect_needs_slot_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    redir_q |-> ($past(pend_q) && $past(slot_done)));
  p_redirect_pulse_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    redir_q |=> !redir_q);
  p_redirect_pc_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    redir_q |-> (rpc_q == $past(hold_q)));
endmodule

// File: rtl/rb_branch_unit.sv
module rb_branch_unit
  import rb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DISP_W  = 8,
  parameter int unsigned OP_W    = 8,
  parameter logic [7:0]  OP_BASE = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              flag_s_i,
  input  logic              flag_z_i,
  input  logic              flag_cy_i,
  input  logic              flag_ov_i,
  input  logic              slot_done_i,
  output logic              dec_valid_o,
  output logic              is_br_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] fall_pc_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o
);
  localparam int unsigned SKIP = 1 + (DISP_W + 7) / 8;

  logic              rst_q_n;
  rb_flags_t         flags;
  logic              c_is_br, c_take;
  logic [ADDR_W-1:0] c_fall, c_tgt;

  logic              vld_q, vld_d;
  logic              br_q, br_d, tk_q, tk_d;
  logic [ADDR_W-1:0] fall_q, fall_d, tgt_q, tgt_d;

  assign flags = '{s: flag_s_i, z: flag_z_i, cy: flag_cy_i, ov: flag_ov_i};

  rb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  rb_cond #(.OP_W(OP_W), .OP_BASE(OP_W'(OP_BASE))) u_cond (
    .opcode(opcode_i), .flags(flags), .is_br(c_is_br), .take(c_take)
  );

  rb_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SKIP(SKIP)) u_tgt (
    .pc(pc_i), .disp(disp_i), .fall_pc(c_fall), .tgt_pc(c_tgt)
  );

  rb_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk(clk), .rst_q_n(rst_q_n), .issue(issue_i),
    .load_taken(issue_i & c_take), .load_pc(c_tgt),
    .slot_done(slot_done_i),
    .redirect(redirect_o), .redirect_pc(redirect_pc_o)
  );

  always_comb begin
    vld_d  = issue_i;
    br_d   = c_is_br;
    tk_d   = c_take;
    fall_d = c_fall;
    tgt_d  = c_tgt;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q  <= 1'b0;
      br_q   <= 1'b0;
      tk_q   <= 1'b0;
      fall_q <= '0;
      tgt_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (issue_i) begin
        br_q   <= br_d;
        tk_q   <= tk_d;
        fall_q <= fall_d;
        tgt_q  <= tgt_d;
      end
    end
  end

  assign dec_valid_o = vld_q;
  assign is_br_o     = br_q;
  assign taken_o     = tk_q;
  assign fall_pc_o   = fall_q;
  assign target_o    = tgt_q;

  p_dec_follows_issue_r12: assert property (@(posedge clk) disable iff (!rst_q_n)
    vld_q |-> $past(issue_i));
  p_fall_addr_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    vld_q |-> (fall_q == ADDR_W'($past(pc_i) + ADDR_W'(SKIP))));
  p_bra_taken_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (vld_q && ($past(opcode_i) == OP_W'(OP_BASE))) |-> tk_q);
  p_taken_is_branch_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    tk_q |-> br_q);
  p_redirect_matches_target_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    redirect_o |-> (redirect_pc_o == tgt_q));
endmodule

// File: tb/sim_rb_branch_unit.sv
module sim_rb_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i, slot_done_i;
  logic [7:0]  opcode_i, disp_i;
  logic [15:0] pc_i;
  logic        fs, fz, fc, fv;
  logic        dec_valid_o, is_br_o, taken_o, redirect_o;
  logic [15:0] fall_pc_o, target_o, redirect_pc_o;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  rb_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .opcode_i(opcode_i),
    .disp_i(disp_i), .pc_i(pc_i), .flag_s_i(fs), .flag_z_i(fz),
    .flag_cy_i(fc), .flag_ov_i(fv), .slot_done_i(slot_done_i),
    .dec_valid_o(dec_valid_o), .is_br_o(is_br_o), .taken_o(taken_o),
    .fall_pc_o(fall_pc_o), .target_o(target_o), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_take(input logic [7:0] op, input logic s, z, c, v);
    case (op)
      8'h05: return 1'b1;          // R3
      8'h06: return (s ^ v) == 0;  // R4
      8'h07: return (s ^ v) == 1;  // R4
      8'h08: return !z;            // R5
      8'h09: return z;             // R5
      8'h0A: return !s;            // R6
      8'h0B: return s;             // R6
      8'h0C: return !c;            // R7
      8'h0D: return c;             // R7
      8'h0E: return !v;            // R7
      8'h0F: return v;             // R7
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input logic [7:0] op, input logic [3:0] fl,
                       input logic [15:0] pc, input logic [7:0] d, input int gap);
    bit          t  = exp_take(op, fl[3], fl[2], fl[1], fl[0]);
    bit          br = (op >= 8'h05) && (op <= 8'h0F);
    logic [15:0] fall = pc + 16'd2;
    logic [15:0] tgt  = fall + {{8{d[7]}}, d};
    string       rq;
    @(negedge clk);
    issue_i = 1'b1; opcode_i = op; pc_i = pc; disp_i = d;
    {fs, fz, fc, fv} = fl;
    @(negedge clk);
    issue_i = 1'b0;
    if (op == 8'h05) rq = "R3";
    else if (op == 8'h06 || op == 8'h07) rq = "R4";
    else if (op == 8'h08 || op == 8'h09) rq = "R5";
    else if (op == 8'h0A || op == 8'h0B) rq = "R6";
    else if (br) rq = "R7";
    else rq = "R2";
    chk("R12 dec_valid", {31'd0, dec_valid_o}, 32'd1);
    chk("R2 is_br", {31'd0, is_br_o}, {31'd0, br});
    chk({rq, " taken"}, {31'd0, taken_o}, {31'd0, t});
    chk("R9 fall_pc", {16'd0, fall_pc_o}, {16'd0, fall});
    if (br) chk("R8 target", {16'd0, target_o}, {16'd0, tgt});
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      chk("R10 no early redirect", {31'd0, redirect_o}, 32'd0);
    end
    slot_done_i = 1'b1;
    @(negedge clk);
    slot_done_i = 1'b0;
    if (gap == 0) chk("R12 dec pulse", {31'd0, dec_valid_o}, 32'd0);
    if (t) begin
      chk("R10 redirect", {31'd0, redirect_o}, 32'd1);
      chk("R10 redirect_pc", {16'd0, redirect_pc_o}, {16'd0, tgt});
    end else begin
      chk("R11 no redirect", {31'd0, redirect_o}, 32'd0);
    end
    @(negedge clk);
    chk("R10 single pulse", {31'd0, redirect_o}, 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        misses++;
        vectors++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; issue_i = 1'b0; slot_done_i = 1'b0;
    opcode_i = '0; disp_i = '0; pc_i = '0; {fs, fz, fc, fv} = 4'h0;
    repeat (3) @(negedge clk);
    chk("R1 dec_valid", {31'd0, dec_valid_o}, 32'd0);
    chk("R1 redirect", {31'd0, redirect_o}, 32'd0);
    chk("R1 target", {16'd0, target_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {30'd0, dec_valid_o, taken_o}, 32'd0);
    repeat (3) @(negedge clk);

    // wrap corners for R8 and R9
    apply(8'h05, 4'h0, 16'hFFFE, 8'h7F, 0);
    apply(8'h05, 4'h0, 16'hFFFF, 8'h01, 1);
    apply(8'h05, 4'h0, 16'h0001, 8'h80, 0);
    apply(8'h05, 4'h0, 16'h0000, 8'hFE, 2);
    apply(8'h09, 4'h4, 16'h7FFE, 8'h00, 0);

    for (int op = 0; op < 256; op++) begin
      for (int f = 0; f < 16; f++) begin
        apply(8'(op), 4'(f), 16'(op * 257 + f * 4099), 8'(op * 37 + f * 11),
              ((op + f) % 7 == 0) ? 2 : 0);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule